// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides which pending exception a processor core takes and works out the state the core must load when it does. Each cycle it looks at seven request lines (reset, undefined instruction, supervisor call, prefetch abort, data abort, normal interrupt and fast interrupt), the current 32-bit status word, a vector-base select bit and the return address supplied by the pipeline. When a request qualifies, it produces the whole entry state one clock later under a single-cycle strobe: the new mode, the new status word, the word to save into the new mode's saved status register, the link value and the vector address for the program counter.

The two interrupt lines can be masked by bits of the current status word. The other requests cannot. When several requests are present together, a fixed priority picks exactly one. The core copies the strobed values into its register file and program counter. Between strobes the outputs keep the values from the last entry.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, `takeStrobe` is 0 and every data output is 0.
- R2: A reset request produces vector offset 0x00, mode 5'b10011, new status 0x000001D3 (bits 8, 7 and 6 set, every other bit 0 except the mode field), and a saved status and link value of 0.
- R3: An undefined-instruction request produces offset 0x04 and mode 5'b11011. A supervisor-call request produces offset 0x08 and mode 5'b10011. Neither changes bit 8 or bit 6 of the status word.
- R4: A prefetch-abort request produces offset 0x0C and a data-abort request produces offset 0x10. Both use mode 5'b10111 and also set bit 8 of the new status.
- R5: A normal interrupt is taken only while status bit 7 is 0. It produces offset 0x18 and mode 5'b10010.
- R6: A fast interrupt is taken only while status bit 6 is 0. It produces offset 0x1C and mode 5'b10001, and it also sets bits 8 and 6 of the new status.
- R7: The vector address is the offset added to a base. The base is 0x00000000 when `highVec` is 0 and 0xFFFF0000 when it is 1.
- R8: When requests arrive together, exactly one is taken, in this order from first to last: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, supervisor call. A masked interrupt does not take part.
- R9: A qualifying request sampled at a rising edge raises `takeStrobe` for the following cycle only. When no request qualifies, `takeStrobe` stays 0 and every data output keeps its previous value.
- R10: On every entry other than reset, the new status is the old status with bits 4:0 replaced by the new mode, bit 5 cleared and bit 7 set. The saved status equals the old status word and the link value equals `retAddr`, both taken from the cycle in which the request was sampled.
- R11: `newMode` always equals bits 4:0 of `newStatus` while `takeStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| statusIn | input | 32 | Current status word (bit 8 async-abort mask, bit 7 interrupt mask, bit 6 fast-interrupt mask, bit 5 16-bit state, bits 4:0 mode) |
| resetReq | input | 1 | Core reset exception request |
| undefReq | input | 1 | Undefined instruction request |
| svcReq | input | 1 | Supervisor call request |
| pabtReq | input | 1 | Prefetch abort request |
| dabtReq | input | 1 | Data abort request |
| irqReq | input | 1 | Normal interrupt line |
| fiqReq | input | 1 | Fast interrupt line |
| highVec | input | 1 | Selects the high vector base |
| retAddr | input | 32 | Return address for the link register |
| takeStrobe | output | 1 | One-cycle entry strobe |
| newMode | output | 5 | Mode to enter |
| newStatus | output | 32 | Status word to load |
| savedStatus | output | 32 | Value for the new mode's saved status register |
| linkOut | output | 32 | Value for the new mode's link register |
| vectorPc | output | 32 | Vector address for the program counter |

## Verification
Every cycle, the assertions check the following. An interrupt is never entered while its mask bit was set. Each entry sets bit 7 and clears bit 5. The mode output agrees with the status word. The vector lies within the selected base's 32-byte window. A non-reset entry saves the old status and return address. The outputs hold when nothing qualifies. Only the directed scenarios can show the exact offset and mode for each exception kind, the extra mask bits per kind, the full priority order when requests collide, and the fixed reset status value. Those scenarios compare each output against a model computed independently in the bench.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int BIT_A = 8;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;
  localparam int MODE_W = 5;
  localparam int NUM_REQ = 7;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

  typedef enum logic [2:0] {
    EXC_RESET,
    EXC_DABT,
    EXC_FIQ,
    EXC_IRQ,
    EXC_PABT,
    EXC_UNDEF,
    EXC_SVC
  } excKind_e;

  typedef struct packed {
    logic     fire;
    excKind_e kind;
  } entryCtl_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqLines,
  input  logic               irqMasked,
  input  logic               fiqMasked,
  output entryCtl_t          ctl
);

  logic [NUM_REQ-1:0] qualified;

  always_comb begin
    qualified = reqLines;
    qualified[int'(EXC_FIQ)] = reqLines[int'(EXC_FIQ)] & ~fiqMasked;
    qualified[int'(EXC_IRQ)] = reqLines[int'(EXC_IRQ)] & ~irqMasked;
  end

  always_comb begin
    ctl.fire = |qualified;
    ctl.kind = EXC_RESET;
    for (int idx = NUM_REQ - 1; idx >= 0; idx--) begin
      if (qualified[idx]) ctl.kind = excKind_e'(idx);
    end
  end

  AST_FIRE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fire |-> (reqLines != '0)); // R9

  AST_NO_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.kind == EXC_IRQ) |-> (!irqMasked && !reqLines[int'(EXC_RESET)])); // R8

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  entryCtl_t         ctl,
  input  logic [DATA_W-1:0] statusIn,
  input  logic              highVec,
  input  logic [DATA_W-1:0] retAddr,
  output logic              takeStrobe,
  output logic [MODE_W-1:0] newMode,
  output logic [DATA_W-1:0] newStatus,
  output logic [DATA_W-1:0] savedStatus,
  output logic [DATA_W-1:0] linkOut,
  output logic [DATA_W-1:0] vectorPc
);

  localparam int OFF_W = 5;

  logic [OFF_W-1:0]  vecOff;
  logic [MODE_W-1:0] tgtMode;
  logic              setA;
  logic              setF;
  logic [DATA_W-1:0] baseAddr;
  logic [DATA_W-1:0] nxtStatus;
  logic [DATA_W-1:0] nxtSaved;
  logic [DATA_W-1:0] nxtLink;

  always_comb begin
    vecOff  = 5'h00;
    tgtMode = MODE_SVC;
    setA    = 1'b0;
    setF    = 1'b0;
    case (ctl.kind)
      EXC_RESET: begin vecOff = 5'h00; tgtMode = MODE_SVC; setA = 1'b1; setF = 1'b1; end
      EXC_UNDEF: begin vecOff = 5'h04; tgtMode = MODE_UND; end
      EXC_SVC:   begin vecOff = 5'h08; tgtMode = MODE_SVC; end
      EXC_PABT:  begin vecOff = 5'h0C; tgtMode = MODE_ABT; setA = 1'b1; end
      EXC_DABT:  begin vecOff = 5'h10; tgtMode = MODE_ABT; setA = 1'b1; end
      EXC_IRQ:   begin vecOff = 5'h18; tgtMode = MODE_IRQ; end
      EXC_FIQ:   begin vecOff = 5'h1C; tgtMode = MODE_FIQ; setA = 1'b1; setF = 1'b1; end
      default:   begin vecOff = 5'h00; tgtMode = MODE_SVC; end
    endcase
  end

  assign baseAddr = highVec ? HIGH_BASE : '0;

  always_comb begin
    if (ctl.kind == EXC_RESET) begin
      nxtStatus = '0;
      nxtSaved  = '0;
      nxtLink   = '0;
    end else begin
      nxtStatus = statusIn;
      nxtSaved  = statusIn;
      nxtLink   = retAddr;
    end
    nxtStatus[MODE_W-1:0] = tgtMode;
    nxtStatus[BIT_T]      = 1'b0;
    nxtStatus[BIT_I]      = 1'b1;
    if (setA) nxtStatus[BIT_A] = 1'b1;
    if (setF) nxtStatus[BIT_F] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeStrobe  <= 1'b0;
      newMode     <= '0;
      newStatus   <= '0;
      savedStatus <= '0;
      linkOut     <= '0;
      vectorPc    <= '0;
    end else begin
      takeStrobe <= ctl.fire;
      if (ctl.fire) begin
        newMode     <= tgtMode;
        newStatus   <= nxtStatus;
        savedStatus <= nxtSaved;
        linkOut     <= nxtLink;
        vectorPc    <= baseAddr + DATA_W'(vecOff);
      end
    end
  end

  AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (takeStrobe && newMode == MODE_IRQ) |-> !$past(statusIn[BIT_I])); // R5

  AST_FIQ_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (takeStrobe && newMode == MODE_FIQ) |-> !$past(statusIn[BIT_F])); // R6

  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (newStatus[BIT_I] && !newStatus[BIT_T])); // R10

  AST_MODE_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> (newStatus[MODE_W-1:0] == newMode)); // R11

  AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    takeStrobe |-> ((vectorPc ^ ($past(highVec) ? HIGH_BASE : '0)) < DATA_W'(32))); // R7

  AST_SAVE_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (takeStrobe && vectorPc[OFF_W-1:0] != '0) |->
      (savedStatus == $past(statusIn) && linkOut == $past(retAddr))); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |=> ($stable(vectorPc) && $stable(newStatus) && !takeStrobe)); // R9

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] HIGH_BASE = 32'hFFFF_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] statusIn,
  input  logic              resetReq,
  input  logic              undefReq,
  input  logic              svcReq,
  input  logic              pabtReq,
  input  logic              dabtReq,
  input  logic              irqReq,
  input  logic              fiqReq,
  input  logic              highVec,
  input  logic [DATA_W-1:0] retAddr,
  output logic              takeStrobe,
  output logic [MODE_W-1:0] newMode,
  output logic [DATA_W-1:0] newStatus,
  output logic [DATA_W-1:0] savedStatus,
  output logic [DATA_W-1:0] linkOut,
  output logic [DATA_W-1:0] vectorPc
);

  logic [NUM_REQ-1:0] reqLines;
  entryCtl_t          ctl;

  always_comb begin
    reqLines = '0;
    reqLines[int'(EXC_RESET)] = resetReq;
    reqLines[int'(EXC_DABT)]  = dabtReq;
    reqLines[int'(EXC_FIQ)]   = fiqReq;
    reqLines[int'(EXC_IRQ)]   = irqReq;
    reqLines[int'(EXC_PABT)]  = pabtReq;
    reqLines[int'(EXC_UNDEF)] = undefReq;
    reqLines[int'(EXC_SVC)]   = svcReq;
  end

  exc_arbiter u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .reqLines  (reqLines),
    .irqMasked (statusIn[BIT_I]),
    .fiqMasked (statusIn[BIT_F]),
    .ctl       (ctl)
  );

  exc_datapath #(
    .DATA_W    (DATA_W),
    .HIGH_BASE (HIGH_BASE)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .statusIn    (statusIn),
    .highVec     (highVec),
    .retAddr     (retAddr),
    .takeStrobe  (takeStrobe),
    .newMode     (newMode),
    .newStatus   (newStatus),
    .savedStatus (savedStatus),
    .linkOut     (linkOut),
    .vectorPc    (vectorPc)
  );

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] statusIn = '0;
  logic        resetReq = 1'b0, undefReq = 1'b0, svcReq = 1'b0, pabtReq = 1'b0;
  logic        dabtReq = 1'b0, irqReq = 1'b0, fiqReq = 1'b0, highVec = 1'b0;
  logic [31:0] retAddr = '0;
  logic        takeStrobe;
  logic [4:0]  newMode;
  logic [31:0] newStatus, savedStatus, linkOut, vectorPc;

  int checks = 0;
  int errors = 0;

  logic [4:0]  hMode = '0;
  logic [31:0] hStatus = '0, hSaved = '0, hLink = '0, hVec = '0;

  always #4 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .statusIn(statusIn),
    .resetReq(resetReq), .undefReq(undefReq), .svcReq(svcReq),
    .pabtReq(pabtReq), .dabtReq(dabtReq), .irqReq(irqReq), .fiqReq(fiqReq),
    .highVec(highVec), .retAddr(retAddr),
    .takeStrobe(takeStrobe), .newMode(newMode), .newStatus(newStatus),
    .savedStatus(savedStatus), .linkOut(linkOut), .vectorPc(vectorPc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // r bit order: 0 reset, 1 data abort, 2 fiq, 3 irq, 4 prefetch abort, 5 undefined, 6 svc
  function automatic void model(input logic [6:0] r, input logic [31:0] st, input logic hv,
                                input logic [31:0] ret, output logic f, output logic [4:0] m,
                                output logic [31:0] ns, output logic [31:0] sv,
                                output logic [31:0] lk, output logic [31:0] vec);
    logic [6:0] q;
    int k;
    logic [7:0] off;
    logic a, ff;
    q = r;
    q[2] = r[2] & ~st[6];
    q[3] = r[3] & ~st[7];
    k = -1;
    for (int i = 6; i >= 0; i--) if (q[i]) k = i;
    f = (k >= 0);
    a = 1'b0; ff = 1'b0; off = 8'h00; m = 5'b10011;
    case (k)
      0: begin off = 8'h00; m = 5'b10011; a = 1'b1; ff = 1'b1; end
      1: begin off = 8'h10; m = 5'b10111; a = 1'b1; end
      2: begin off = 8'h1C; m = 5'b10001; a = 1'b1; ff = 1'b1; end
      3: begin off = 8'h18; m = 5'b10010; end
      4: begin off = 8'h0C; m = 5'b10111; a = 1'b1; end
      5: begin off = 8'h04; m = 5'b11011; end
      6: begin off = 8'h08; m = 5'b10011; end
      default: ;
    endcase
    if (k == 0) begin
      ns = 32'h0000_01D3; sv = '0; lk = '0;
    end else begin
      ns = (st & ~32'h0000_003F) | {27'd0, m} | 32'h80;
      if (a) ns = ns | 32'h100;
      if (ff) ns = ns | 32'h40;
      sv = st; lk = ret;
    end
    vec = (hv ? 32'hFFFF_0000 : 32'h0) + {24'd0, off};
  endfunction

  task automatic scenario(input string tag, input logic [6:0] r, input logic [31:0] st,
                          input logic hv, input logic [31:0] ret);
    logic f; logic [4:0] m; logic [31:0] ns, sv, lk, vec;
    model(r, st, hv, ret, f, m, ns, sv, lk, vec);
    @(negedge clk);
    {svcReq, undefReq, pabtReq, irqReq, fiqReq, dabtReq, resetReq} = r;
    statusIn = st; highVec = hv; retAddr = ret;
    @(negedge clk);
    if (f) begin
      hMode = m; hStatus = ns; hSaved = sv; hLink = lk; hVec = vec;
    end
    chk({tag, " strobe R9"}, {31'd0, takeStrobe}, {31'd0, f});
    chk({tag, " mode"}, {27'd0, newMode}, {27'd0, hMode});
    chk({tag, " status R10"}, newStatus, hStatus);
    chk({tag, " saved R10"}, savedStatus, hSaved);
    chk({tag, " link R10"}, linkOut, hLink);
    chk({tag, " vector R7"}, vectorPc, hVec);
    {svcReq, undefReq, pabtReq, irqReq, fiqReq, dabtReq, resetReq} = '0;
    @(negedge clk);
    chk({tag, " strobe drop R9"}, {31'd0, takeStrobe}, 32'd0);
    chk({tag, " hold R9"}, vectorPc, hVec);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", {31'd0, takeStrobe}, 32'd0);
    chk("R1 vector in reset", vectorPc, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 strobe after reset", {31'd0, takeStrobe}, 32'd0);
    chk("R1 status after reset", newStatus, 32'd0);
    chk("R1 link after reset", linkOut, 32'd0);

    scenario("R2 reset request", 7'b000_0001, 32'hF000_0030, 1'b0, 32'h0000_1234);
    scenario("R3 undefined", 7'b010_0000, 32'hF000_0130, 1'b0, 32'h0000_2004);
    scenario("R3 supervisor call", 7'b100_0000, 32'h6000_0050, 1'b0, 32'h0000_3008);
    scenario("R4 prefetch abort", 7'b001_0000, 32'h8000_0010, 1'b0, 32'h0000_4000);
    scenario("R4 data abort", 7'b000_0010, 32'h2000_0030, 1'b0, 32'h0000_5010);
    scenario("R5 irq open", 7'b000_1000, 32'h4000_0010, 1'b0, 32'h0000_6004);
    scenario("R5 irq masked", 7'b000_1000, 32'h4000_0090, 1'b0, 32'h0000_6104);
    scenario("R6 fiq open", 7'b000_0100, 32'h1000_0010, 1'b0, 32'h0000_7004);
    scenario("R6 fiq masked", 7'b000_0100, 32'h1000_0050, 1'b0, 32'h0000_7104);
    scenario("R7 high base irq", 7'b000_1000, 32'h0000_0010, 1'b1, 32'h0000_8000);
    scenario("R7 high base reset", 7'b000_0001, 32'h0000_0010, 1'b1, 32'h0000_8100);
    scenario("R8 all together", 7'b111_1111, 32'h0000_0010, 1'b0, 32'h0000_9000);
    scenario("R8 dabt over fiq", 7'b111_1110, 32'h0000_0010, 1'b0, 32'h0000_9100);
    scenario("R8 fiq over irq", 7'b111_1100, 32'h0000_0010, 1'b0, 32'h0000_9200);
    scenario("R8 irq over pabt", 7'b111_1000, 32'h0000_0010, 1'b0, 32'h0000_9300);
    scenario("R8 masked fiq skipped", 7'b111_1100, 32'h0000_0050, 1'b0, 32'h0000_9400);
    scenario("R8 pabt over undef", 7'b111_0000, 32'h0000_0010, 1'b0, 32'h0000_9500);
    scenario("R8 undef over svc", 7'b110_0000, 32'h0000_0010, 1'b0, 32'h0000_9600);
    scenario("R11 mode field fiq", 7'b000_0100, 32'hFFFF_FE3F, 1'b1, 32'h0000_9700);

    chk("R11 mode vs status", {27'd0, newMode}, {27'd0, newStatus[4:0]});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule